// File: doc/BRIEF.md
# NAND Target Interface Front End

This block is a synthesizable target-side model of the asynchronous control port of a NAND target with several dies. It oversamples the chip-enable, command-latch, address-latch, write and read strobes with a system clock. From their edges it decodes command, address, data-in and data-out cycles. Each die owns one page of cache bytes. A single byte pointer moves through the page of the die that is currently selected.

Program and erase confirm commands start a fixed, parameterized busy period on the selected die. While that period runs, the die rejects data movement but still answers status reads. Write protection is sampled continuously and blocks both confirm commands. The ready/busy output stays low while any die is busy.

The block is used as a device model in a controller's test environment, or as the front of a flash emulator. NUM_DIES and PAGE_BYTES must be powers of two, and NUM_DIES must be at least 2.

Top module: `nand_target_fe`

## Requirements
- R1: After reset every die is ready, rb_n is 1, io_oe is 0, the byte pointer is 0 and the block is in data mode.
- R2: On a rising edge of we_n, with ce_n, cle and ale low, re_n high and the selected die ready, io_in is stored at the pointer in that die's cache page. The pointer then advances by one and wraps from PAGE_BYTES-1 to 0.
- R3: On a falling edge of re_n in data mode, with ce_n, cle and ale low, we_n high and the selected die ready, the byte at the pointer is driven on io_out. io_oe is set in the same clock, and the pointer advances and wraps. io_oe clears on the first clock that samples re_n or ce_n high.
- R4: Every command cycle resets the pointer to 0. A command cycle is a rising edge of we_n with ce_n low, cle high and ale low.
- R5: An accepted confirm holds the selected die busy for exactly BUSY_CYCLES clocks. The confirm is 10h after setup 80h, or D0h after setup 60h, with the die ready and wp_n high. rb_n is low while at least one die is busy.
- R6: While the selected die is busy, data-in cycles leave its cache and the pointer unchanged, and data-mode read strobes leave io_oe at 0.
- R7: Command 70h or 78h enters status mode. In status mode every read strobe returns the status byte, even while the die is busy. The status byte has bit 7 equal to wp_n as sampled, bit 6 equal to the ready flag of the selected die, and bits 5 to 0 equal to 0.
- R8: Status mode entered by 70h ends at the next command of any value. Status mode entered by 78h persists across other commands and ends only at command 00h.
- R9: While wp_n is low, confirm commands are rejected and the die stays ready. wp_n is sampled whatever the level of ce_n.
- R10: An address cycle selects die io_in[$clog2(NUM_DIES)-1:0]. An address cycle is a rising edge of we_n with ce_n low, ale high and cle low. rb_n is the AND of all die ready flags, so a second die remains usable and reports ready while the other is busy.
- R11: Strobes while ce_n is high change neither the cache nor the pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| we_n | input | 1 | Write strobe, active low |
| re_n | input | 1 | Read strobe, active low |
| wp_n | input | 1 | Write protect, active low |
| io_in | input | 8 | Byte from the host bus |
| io_out | output | 8 | Byte driven toward the host bus |
| io_oe | output | 1 | Output enable for io_out |
| rb_n | output | 1 | Ready/busy, low while any die is busy |

## Verification
Data movement is exercised with directed page fills, with writes that run past the page end to force the pointer to wrap, and with random write and read bursts of 1 to 20 bytes on random dies. Comparing these against a bench page model separates pointer-advance, wrap and command-reset errors from per-die addressing errors. Busy-phase sequences run data writes, data reads and status reads against the busy die and check that only the status reads get through. Confirms issued with wp_n low, and the 70h versus 78h exit cases, separate write-protect gating from status-mode handling. A run where one die is busy and the other is selected shows whether rb_n combines the dies or follows only the selected one.

// File: rtl/nand_target_fe.sv
module nand_target_fe #(
  parameter int NUM_DIES    = 2,
  parameter int PAGE_BYTES  = 16,
  parameter int BUSY_CYCLES = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       cle,
  input  logic       ale,
  input  logic       we_n,
  input  logic       re_n,
  input  logic       wp_n,
  input  logic [7:0] io_in,
  output logic [7:0] io_out,
  output logic       io_oe,
  output logic       rb_n
);
  localparam int SEL_W = $clog2(NUM_DIES);
  localparam int PTR_W = $clog2(PAGE_BYTES);
  localparam int IDX_W = SEL_W + PTR_W;
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  typedef enum logic [1:0] {SU_NONE, SU_PROG, SU_ERASE} setup_t;

  logic             we_q, re_q, wp_q;
  logic [SEL_W-1:0] sel;
  logic [PTR_W-1:0] ptr;
  logic             stat_mode, stat_sticky;
  setup_t           setup;
  logic [NUM_DIES-1:0] ready;
  logic [7:0]       cache [NUM_DIES*PAGE_BYTES];

  wire we_rise  = ~we_q & we_n;
  wire re_fall  = re_q & ~re_n;
  wire bus_data = ~ce_n & ~cle & ~ale;
  wire cmd_cyc  = we_rise & ~ce_n & cle & ~ale;
  wire adr_cyc  = we_rise & ~ce_n & ale & ~cle;
  wire din_cyc  = we_rise & bus_data & re_n;
  wire dout_cyc = re_fall & bus_data & we_n;
  wire sel_rdy  = ready[sel];
  wire [IDX_W-1:0] idx = {sel, ptr};
  wire [PTR_W-1:0] ptr_nx = (ptr == PTR_W'(PAGE_BYTES - 1)) ? '0 : ptr + 1'b1;
  wire [7:0] status = {wp_q, sel_rdy, 6'b0};

  wire confirm = cmd_cyc & sel_rdy & wp_n &
                 (((setup == SU_PROG)  & (io_in == 8'h10)) |
                  ((setup == SU_ERASE) & (io_in == 8'hD0)));
  wire [NUM_DIES-1:0] start = {NUM_DIES{confirm}} & (NUM_DIES'(1) << sel);

  assign rb_n = &ready;

  for (genvar g = 0; g < NUM_DIES; g++) begin : g_die
    logic [CNT_W-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt      <= '0;
        ready[g] <= 1'b1;
      end else if (start[g]) begin
        cnt      <= CNT_W'(BUSY_CYCLES);
        ready[g] <= 1'b0;
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) ready[g] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (din_cyc && sel_rdy) cache[idx] <= io_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q        <= 1'b1;
      re_q        <= 1'b1;
      wp_q        <= 1'b0;
      sel         <= '0;
      ptr         <= '0;
      stat_mode   <= 1'b0;
      stat_sticky <= 1'b0;
      setup       <= SU_NONE;
      io_out      <= '0;
      io_oe       <= 1'b0;
    end else begin
      we_q <= we_n;
      re_q <= re_n;
      wp_q <= wp_n;
      if (cmd_cyc) begin
        ptr <= '0;
        case (io_in)
          8'h00: begin stat_mode <= 1'b0; stat_sticky <= 1'b0; setup <= SU_NONE; end
          8'h70: begin stat_mode <= 1'b1; stat_sticky <= 1'b0; end
          8'h78: begin stat_mode <= 1'b1; stat_sticky <= 1'b1; end
          8'h80: begin stat_mode <= stat_sticky; setup <= SU_PROG; end
          8'h60: begin stat_mode <= stat_sticky; setup <= SU_ERASE; end
          default: begin stat_mode <= stat_sticky; setup <= SU_NONE; end
        endcase
      end
      if (adr_cyc) sel <= io_in[SEL_W-1:0];
      if (din_cyc && sel_rdy) ptr <= ptr_nx;
      if (dout_cyc && stat_mode) begin
        io_out <= status;
        io_oe  <= 1'b1;
      end else if (dout_cyc && sel_rdy) begin
        io_out <= cache[idx];
        io_oe  <= 1'b1;
        ptr    <= ptr_nx;
      end else if (re_n || ce_n) begin
        io_oe <= 1'b0;
      end
    end
  end

  p_wp_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_cyc && !wp_n && sel_rdy) |=> ready[$past(sel)]);
  p_busy_din_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (din_cyc && !sel_rdy) |=> (ptr == $past(ptr)));
  p_busy_dout_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_cyc && !stat_mode && !sel_rdy && !io_oe) |=> !io_oe);
  p_ce_drops_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ce_n) |=> !io_oe);
  p_confirm_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    confirm |=> !rb_n);
endmodule

// File: tb/nand_target_fe_bench.sv
module nand_target_fe_bench;
  localparam int NDIE = 2;
  localparam int PAGE = 16;
  localparam int BUSY = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b0, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1, wp_n = 1'b1;
  logic [7:0] io_in = '0;
  logic [7:0] io_out;
  logic io_oe, rb_n;

  int checks = 0;
  int fails = 0;
  logic [7:0] mcache [NDIE][PAGE];
  int mptr = 0;
  int mdie = 0;

  always #2.5 clk = ~clk;

  nand_target_fe #(.NUM_DIES(NDIE), .PAGE_BYTES(PAGE), .BUSY_CYCLES(BUSY)) u_nand_target_fe (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
    .re_n(re_n), .wp_n(wp_n), .io_in(io_in), .io_out(io_out), .io_oe(io_oe), .rb_n(rb_n));

  function automatic logic [7:0] status_exp(input logic wp, input logic rdy);
    return {wp, rdy, 6'b0};
  endfunction

  function automatic int next_ptr(input int p);
    return (p == PAGE - 1) ? 0 : p + 1;
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic c, input logic a, input logic [7:0] d);
    @(negedge clk); cle = c; ale = a; io_in = d; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); cle = 1'b0; ale = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] d);
    strobe(1'b1, 1'b0, d);
    mptr = 0;
  endtask

  task automatic addr(input int die);
    strobe(1'b0, 1'b1, 8'(die));
    mdie = die;
  endtask

  task automatic din(input logic [7:0] d);
    strobe(1'b0, 1'b0, d);
    mcache[mdie][mptr] = d;
    mptr = next_ptr(mptr);
  endtask

  task automatic rd(output logic [7:0] v, output logic oe);
    @(negedge clk); re_n = 1'b0;
    @(negedge clk); v = io_out; oe = io_oe; re_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd_data(input string req);
    logic [7:0] v;
    logic oe;
    rd(v, oe);
    chk({req, " oe"}, 32'(oe), 32'd1);
    chk({req, " data"}, 32'(v), 32'(mcache[mdie][mptr]));
    mptr = next_ptr(mptr);
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 4 * BUSY && !rb_n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
  end

  initial begin
    logic [7:0] v;
    logic oe;
    int n;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rb_n after reset", 32'(rb_n), 32'd1);
    chk("R1 io_oe after reset", 32'(io_oe), 32'd0);

    for (int d = 0; d < NDIE; d++) begin
      cmd(8'h80); addr(d);
      for (int i = 0; i < PAGE; i++) din(8'($urandom));
    end
    cmd(8'h00); addr(0);
    for (int i = 0; i < 4; i++) rd_data("R3 page read die0");
    @(negedge clk);
    chk("R3 io_oe cleared after strobe", 32'(io_oe), 32'd0);

    cmd(8'h80); addr(1);
    for (int i = 0; i < PAGE + 5; i++) din(8'($urandom));
    cmd(8'h00); addr(1);
    for (int i = 0; i < PAGE + 3; i++) rd_data("R2 wrap write and read");

    rd_data("R4 mid-page read");
    cmd(8'h00);
    rd_data("R4 pointer reset by command");

    for (int it = 0; it < 25; it++) begin
      int d = int'($urandom_range(NDIE - 1, 0));
      int nw = int'($urandom_range(20, 1));
      int nr = int'($urandom_range(20, 1));
      cmd(8'h80); addr(d);
      for (int i = 0; i < nw; i++) din(8'($urandom));
      cmd(8'h00); addr(d);
      for (int i = 0; i < nr; i++) rd_data("R2 R3 R10 random burst");
    end

    cmd(8'h80); addr(0);
    ce_n = 1'b1;
    strobe(1'b0, 1'b0, 8'hA5);
    ce_n = 1'b0;
    cmd(8'h00);
    rd_data("R11 write with ce_n high ignored");

    cmd(8'h80); addr(0); cmd(8'h10);
    chk("R5 rb_n low after confirm", 32'(rb_n), 32'd0);
    n = 0;
    while (!rb_n && n < 4 * BUSY) begin @(negedge clk); n++; end
    chk("R5 busy length", 32'(n), 32'(BUSY));

    cmd(8'h80); addr(0); cmd(8'h10);
    cmd(8'h00);
    strobe(1'b0, 1'b0, 8'h3C);
    rd(v, oe);
    chk("R6 read while busy no oe", 32'(oe), 32'd0);
    cmd(8'h70);
    rd(v, oe);
    chk("R7 status while busy oe", 32'(oe), 32'd1);
    chk("R7 status while busy", 32'(v), 32'(status_exp(1'b1, 1'b0)));
    rd(v, oe);
    chk("R7 status repeats", 32'(v), 32'(status_exp(1'b1, 1'b0)));
    wait_ready();
    chk("R5 rb_n back high", 32'(rb_n), 32'd1);
    cmd(8'h00);
    rd_data("R6 cache unchanged by busy write");

    cmd(8'h80); addr(1); cmd(8'h10);
    addr(0); cmd(8'h70);
    rd(v, oe);
    chk("R10 idle die reports ready", 32'(v), 32'(status_exp(1'b1, 1'b1)));
    chk("R10 rb_n low while other die busy", 32'(rb_n), 32'd0);
    cmd(8'h00);
    rd_data("R10 idle die serves data");
    wait_ready();

    ce_n = 1'b1; wp_n = 1'b0;
    repeat (2) @(negedge clk);
    ce_n = 1'b0;
    cmd(8'h70);
    rd(v, oe);
    chk("R9 wp sampled with ce_n high", 32'(v), 32'(status_exp(1'b0, 1'b1)));
    cmd(8'h60); addr(0); cmd(8'hD0);
    @(negedge clk);
    chk("R9 erase rejected", 32'(rb_n), 32'd1);
    cmd(8'h80); addr(0); cmd(8'h10);
    @(negedge clk);
    chk("R9 program rejected", 32'(rb_n), 32'd1);
    ce_n = 1'b1; wp_n = 1'b1;
    repeat (2) @(negedge clk);
    ce_n = 1'b0;
    cmd(8'h70);
    rd(v, oe);
    chk("R7 status wp high", 32'(v), 32'(status_exp(1'b1, 1'b1)));

    cmd(8'h30);
    rd_data("R8 70h mode ends on next command");
    cmd(8'h78);
    cmd(8'h30);
    rd(v, oe);
    chk("R8 78h mode persists", 32'(v), 32'(status_exp(1'b1, 1'b1)));
    cmd(8'h00);
    rd_data("R8 00h restores data mode");

    summary();
  end
endmodule